// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block connects an 8-bit controller core to an external bus on which the low address byte and the data byte share one set of pins. It runs a fixed 12-clock machine cycle made of six states, two clocks each. In the last clock of every machine cycle it offers a slot. The core can place one request in that slot: an opcode fetch, a data read or write through a 16-bit pointer, or a data read or write through an 8-bit indirect address. The block then drives the shared low byte port, the high byte port, the address latch strobe, the program-store read strobe and the data read and write strobes for that machine cycle. It also returns the bytes that the external memory places on the bus.

An external latch captures the low address when the latch strobe falls. The latch strobe pulses twice per machine cycle, at a steady rate of one sixth of the clock, and drops its second pulse during an external data cycle. The external-access input and an address threshold decide whether a fetch uses the bus or is served on chip. In an on-chip fetch the bus stays quiet, and the high byte port keeps showing its port register value.

Top module: `xbus_seq`

## Requirements
- R1: When no external data access takes place (idle, on-chip fetch or external fetch), `ale` is high for exactly two clocks at ticks 0-1 and again at ticks 6-7 of each 12-clock machine cycle. That gives two pulses per cycle.
- R2: In a machine cycle that carries an external data read or write, only the tick 0-1 `ale` pulse occurs and the tick 6-7 pulse is suppressed.
- R3: With `ext_acc` low, every fetch uses the bus. With `ext_acc` high, a fetch uses the bus only if its address is above 0x0FFF; addresses 0x0000-0x0FFF keep `psen_n` high and `ad_oe` low for the whole cycle.
- R4: An external fetch drives `psen_n` low at ticks 2-5 and 8-11. The first half addresses the request address and the second half addresses that address plus one, wrapping at 0xFFFF. The bus byte is sampled at the end of each low window and is presented on `rdata` with a one-clock `rdata_valid`, so there are two bytes per cycle.
- R5: While `ale` is high in a bus cycle, `ad_out` carries the low address byte with `ad_oe` high. During the `psen_n` windows and outside bus cycles, `ad_oe` is low.
- R6: The high byte port shows address bits 15:8 during external fetches and pointer accesses (kinds 2 and 3). It shows `p2_sfr` during indirect accesses (kinds 4 and 5), idle cycles and on-chip fetches. An indirect access uses only address bits 7:0.
- R7: A data read (kind 2 or 4) drives `rd_n` low at ticks 6-11 and keeps `psen_n` high. It releases `ad_oe` after the address phase and returns the byte sampled at the end of the cycle on `rdata`.
- R8: A data write (kind 3 or 5) drives `req_wdata` on `ad_out` with `ad_oe` high from tick 2 to tick 11, drives `wr_n` low at ticks 6-11, and keeps `psen_n` high.
- R9: After any bus cycle, the next idle cycle shows `p2_sfr` on the high byte port and has `ad_oe` low.
- R10: `slot_open` is high in the last clock of each machine cycle, and the request present at that clock edge is taken. The kind encoding is 0 none, 1 fetch, 2 pointer read, 3 pointer write, 4 indirect read, 5 indirect write. Codes 6 and 7, or `req_valid` low, give an idle cycle.
- R11: While `rst` is high, `ale` is low, all read and write strobes are high, and `ad_oe` and `rdata_valid` are low. The first clock after `rst` falls starts a machine cycle with `ale` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present in the slot |
| req_kind | input | 3 | Request kind code |
| req_addr | input | 16 | Fetch address, pointer, or indirect address in bits 7:0 |
| req_wdata | input | 8 | Byte for a data write |
| p2_sfr | input | 8 | High port register value |
| ext_acc | input | 1 | External-access pin, low forces external fetches |
| ad_in | input | 8 | Bus byte read back from the pins |
| ad_out | output | 8 | Low address or write data onto the shared pins |
| ad_oe | output | 8 | Drive enable for the shared pins |
| a_hi | output | 8 | High byte port |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Byte returned from the bus |
| rdata_valid | output | 1 | One-clock pulse with rdata |
| slot_open | output | 1 | Last clock of a machine cycle |

## Verification
The embedded properties check the following on every clock:
- The read and write strobes are never active together, and `psen_n` stays idle while either of them is low.
- `ale` is never high together with any read strobe.
- Every `ale` pulse lasts at least two clocks.

The per-cycle behaviour needs the bench's scenarios. These cases include:
- the pulse count per machine cycle and the dropped second pulse;
- the fetch threshold at 0x0FFF and 0x1000;
- the choice of high byte between pointer and port register;
- the bytes returned from the bus model;
- the restore to the port register after a data cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_FETCH = 3'd1,
    K_RDP   = 3'd2,
    K_WRP   = 3'd3,
    K_RDI   = 3'd4,
    K_WRI   = 3'd5
  } kind_e;
endpackage

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
  parameter int CYC = 12,
  parameter int TW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] tick,
  output logic [TW-1:0] tnx,
  output logic          wrap
);
  assign wrap = (tick == TW'(CYC - 1));
  assign tnx  = wrap ? '0 : tick + 1'b1;

  // Reset parks on the last tick so the first edge after reset opens a cycle.
  always_ff @(posedge clk) begin
    if (rst) tick <= TW'(CYC - 1);
    else     tick <= tnx;
  end
endmodule

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int TPS = 2,
  parameter int TW  = 4,
  parameter logic [AW-1:0] INT_LIMIT = 16'h0FFF
) (
  input  kind_e          kind,
  input  logic [AW-1:0]  addr,
  input  logic           ext_acc,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  p2_sfr,
  input  logic [TW-1:0]  tnx,
  output logic           ale_d,
  output logic           psen_n_d,
  output logic           rd_n_d,
  output logic           wr_n_d,
  output logic           oe_d,
  output logic [DW-1:0]  lo_d,
  output logic [DW-1:0]  hi_d
);
  localparam int HALF = 3 * TPS;

  logic          second;
  logic [TW-1:0] hp;
  logic [AW-1:0] faddr;
  logic          xfetch, is_data, is_wr, is_ptr;

  always_comb begin
    second  = (tnx >= TW'(HALF));
    hp      = second ? tnx - TW'(HALF) : tnx;
    faddr   = addr + {{(AW-1){1'b0}}, second};
    xfetch  = (kind == K_FETCH) && (!ext_acc || (addr > INT_LIMIT));
    is_data = (kind == K_RDP) || (kind == K_WRP) || (kind == K_RDI) || (kind == K_WRI);
    is_wr   = (kind == K_WRP) || (kind == K_WRI);
    is_ptr  = (kind == K_RDP) || (kind == K_WRP);

    // Latch strobe opens each half-cycle, minus the second one of a data cycle.
    ale_d    = (hp < TW'(TPS)) && !(is_data && second);
    psen_n_d = 1'b1;
    rd_n_d   = 1'b1;
    wr_n_d   = 1'b1;
    oe_d     = 1'b0;
    lo_d     = '1;
    hi_d     = p2_sfr;

    if (xfetch) begin
      hi_d     = faddr[AW-1 -: DW];
      lo_d     = faddr[DW-1:0];
      oe_d     = (hp < TW'(TPS));
      psen_n_d = (hp < TW'(TPS));
    end else if (is_data) begin
      hi_d = is_ptr ? addr[AW-1 -: DW] : p2_sfr;
      if (tnx < TW'(TPS)) begin
        lo_d = addr[DW-1:0];
        oe_d = 1'b1;
      end else if (is_wr) begin
        lo_d = wdata;
        oe_d = 1'b1;
      end
      rd_n_d = !(!is_wr && second);
      wr_n_d = !(is_wr && second);
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int TPS = 2,
  parameter logic [AW-1:0] INT_LIMIT = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] p2_sfr,
  input  logic          ext_acc,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic [DW-1:0] ad_oe,
  output logic [DW-1:0] a_hi,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid,
  output logic          slot_open
);
  localparam int CYC  = 6 * TPS;
  localparam int HALF = 3 * TPS;
  localparam int TW   = $clog2(CYC);

  logic [TW-1:0] tick, tnx;
  logic          wrap;

  xbus_timebase #(.CYC(CYC), .TW(TW)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .tnx(tnx), .wrap(wrap)
  );

  assign slot_open = wrap;

  kind_e         kind_in, kind_q, kind_eff;
  logic [AW-1:0] addr_q, addr_eff;
  logic [DW-1:0] wdata_q, wdata_eff;
  logic          ext_q, ext_eff;

  always_comb begin
    kind_in = K_NONE;
    if (req_valid && req_kind >= 3'd1 && req_kind <= 3'd5) kind_in = kind_e'(req_kind);
    kind_eff  = wrap ? kind_in   : kind_q;
    addr_eff  = wrap ? req_addr  : addr_q;
    wdata_eff = wrap ? req_wdata : wdata_q;
    ext_eff   = wrap ? ext_acc   : ext_q;
  end

  logic          ale_d, psen_d, rd_d, wr_d, oe_d;
  logic [DW-1:0] lo_d, hi_d;

  xbus_route #(.AW(AW), .DW(DW), .TPS(TPS), .TW(TW), .INT_LIMIT(INT_LIMIT)) u_rt (
    .kind(kind_eff), .addr(addr_eff), .ext_acc(ext_eff), .wdata(wdata_eff),
    .p2_sfr(p2_sfr), .tnx(tnx), .ale_d(ale_d), .psen_n_d(psen_d),
    .rd_n_d(rd_d), .wr_n_d(wr_d), .oe_d(oe_d), .lo_d(lo_d), .hi_d(hi_d)
  );

  logic xf_q, rdk_q, sample;
  always_comb begin
    xf_q   = (kind_q == K_FETCH) && (!ext_q || (addr_q > INT_LIMIT));
    rdk_q  = (kind_q == K_RDP) || (kind_q == K_RDI);
    sample = ((tick == TW'(HALF - 1)) && xf_q) || (wrap && (xf_q || rdk_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q      <= K_NONE;
      addr_q      <= '0;
      wdata_q     <= '0;
      ext_q       <= 1'b1;
      ale         <= 1'b0;
      psen_n      <= 1'b1;
      rd_n        <= 1'b1;
      wr_n        <= 1'b1;
      ad_oe       <= '0;
      ad_out      <= '1;
      a_hi        <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      if (wrap) begin
        kind_q  <= kind_in;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        ext_q   <= ext_acc;
      end
      ale         <= ale_d;
      psen_n      <= psen_d;
      rd_n        <= rd_d;
      wr_n        <= wr_d;
      ad_oe       <= {DW{oe_d}};
      ad_out      <= lo_d;
      a_hi        <= hi_d;
      rdata_valid <= sample;
      if (sample) rdata <= ad_in;
    end
  end

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  a_r7_psen_quiet: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> psen_n);
  a_r2_no_ale_in_xfer: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !ale);
  a_r5_addr_phase: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n));
  a_r1_ale_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale);
endmodule

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, req_valid, ext_acc;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, p2_sfr, ad_in, ad_out, ad_oe, a_hi, rdata;
  logic        ale, psen_n, rd_n, wr_n, rdata_valid, slot_open;

  xbus_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .p2_sfr(p2_sfr), .ext_acc(ext_acc),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata),
    .rdata_valid(rdata_valid), .slot_open(slot_open)
  );

  // External address latch and memory model
  logic [15:0] lat = 16'h0000;
  always @(posedge clk) if (ale) lat <= {a_hi, ad_out};
  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign ad_in = (!psen_n || !rd_n) ? memf(lat) : 8'hEE;

  int checks = 0, fails = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int n_ale, n_alehi, n_psen, n_rd, n_wr, n_rdv;
  logic [7:0]  rb0, rb1, hi0, lo0, hi_end, wd_seen;
  logic        oe0, oe_end;
  logic [15:0] wa;

  task automatic run(input logic [2:0] k, input logic ex, input logic [15:0] a,
                     input logic [7:0] wd, input logic [7:0] p2, input logic v);
    logic prev;
    @(negedge clk);
    while (!slot_open) @(negedge clk);
    req_valid = v; req_kind = k; req_addr = a; req_wdata = wd; p2_sfr = p2; ext_acc = ex;
    n_ale = 0; n_alehi = 0; n_psen = 0; n_rd = 0; n_wr = 0; n_rdv = 0;
    rb0 = 0; rb1 = 0; wa = 0; wd_seen = 0; prev = 1'b0;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_valid = 0; req_kind = 0;
        hi0 = a_hi; lo0 = ad_out; oe0 = ad_oe[0];
      end
      if (i < 12) begin
        if (ale && !prev) n_ale++;
        if (ale) n_alehi++;
        prev = ale;
        if (!psen_n) n_psen++;
        if (!rd_n) n_rd++;
        if (!wr_n) begin n_wr++; wa = lat; wd_seen = ad_out; end
      end
      if (i >= 1 && rdata_valid) begin
        if (n_rdv == 0) rb0 = rdata; else rb1 = rdata;
        n_rdv++;
      end
      if (i == 12) begin hi_end = a_hi; oe_end = ad_oe[0]; end
    end
  endtask

  // {kind, ext, addr, wdata, p2, ale pulses, psen clocks, rd clocks, wr clocks, bytes}
  localparam logic [51:0] VEC [11] = '{
    {3'd0, 1'b1, 16'h0000, 8'h00, 8'h6D, 2'd2, 4'd0, 4'd0, 4'd0, 2'd0},
    {3'd1, 1'b1, 16'h0123, 8'h00, 8'h6D, 2'd2, 4'd0, 4'd0, 4'd0, 2'd0},
    {3'd1, 1'b0, 16'h0123, 8'h00, 8'h6D, 2'd2, 4'd8, 4'd0, 4'd0, 2'd2},
    {3'd1, 1'b1, 16'h1000, 8'h00, 8'h2B, 2'd2, 4'd8, 4'd0, 4'd0, 2'd2},
    {3'd1, 1'b1, 16'h0FFF, 8'h00, 8'h2B, 2'd2, 4'd0, 4'd0, 4'd0, 2'd0},
    {3'd2, 1'b1, 16'h8A31, 8'h00, 8'h3C, 2'd1, 4'd0, 4'd6, 4'd0, 2'd1},
    {3'd3, 1'b1, 16'h45F0, 8'hA7, 8'h3C, 2'd1, 4'd0, 4'd0, 4'd6, 2'd0},
    {3'd4, 1'b1, 16'h9977, 8'h00, 8'hC3, 2'd1, 4'd0, 4'd6, 4'd0, 2'd1},
    {3'd5, 1'b0, 16'hEE19, 8'h5E, 8'h81, 2'd1, 4'd0, 4'd0, 4'd6, 2'd0},
    {3'd1, 1'b0, 16'hFFFF, 8'h00, 8'h44, 2'd2, 4'd8, 4'd0, 4'd0, 2'd2},
    {3'd6, 1'b1, 16'h1234, 8'h11, 8'h55, 2'd2, 4'd0, 4'd0, 4'd0, 2'd0}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 0; req_kind = 0; req_addr = 0; req_wdata = 0;
    p2_sfr = 8'h6D; ext_acc = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!ale && psen_n && rd_n && wr_n, "R11 strobes in reset", {ale, psen_n, rd_n, wr_n}, 4'b0111);
    chk(ad_oe == 0 && !rdata_valid, "R11 bus released in reset", {ad_oe, rdata_valid}, 0);
    rst = 0;
    @(negedge clk);
    chk(ale == 1'b1, "R11 first cycle starts", ale, 1);

    for (int j = 0; j < 11; j++) begin
      logic [51:0] e;
      logic [2:0] k; logic ex; logic [15:0] a; logic [7:0] wd, p2, ehi;
      int eale, epsen, erd, ewr, enr;
      logic ebus;
      e = VEC[j];
      k = e[51:49]; ex = e[48]; a = e[47:32]; wd = e[31:24]; p2 = e[23:16];
      eale = int'(e[15:14]); epsen = int'(e[13:10]); erd = int'(e[9:6]);
      ewr = int'(e[5:2]); enr = int'(e[1:0]);
      run(k, ex, a, wd, p2, 1'b1);
      chk(n_ale == eale, "R1 R2 ale pulses", n_ale, eale);
      chk(n_alehi == 2 * eale, "R1 ale width", n_alehi, 2 * eale);
      chk(n_psen == epsen, "R3 R4 psen clocks", n_psen, epsen);
      chk(n_rd == erd, "R7 rd clocks", n_rd, erd);
      chk(n_wr == ewr, "R8 wr clocks", n_wr, ewr);
      chk(n_rdv == enr, "R4 R7 R10 returned bytes", n_rdv, enr);
      ebus = ((k == 3'd1) && (epsen != 0)) || (k >= 3'd2 && k <= 3'd5);
      ehi  = (((k == 3'd1) && (epsen != 0)) || k == 3'd2 || k == 3'd3) ? a[15:8] : p2;
      chk(hi0 == ehi, "R6 high byte", hi0, ehi);
      chk(oe0 == ebus, "R5 drive at latch", oe0, ebus);
      if (ebus) chk(lo0 == a[7:0], "R5 low address", lo0, a[7:0]);
      if (enr == 2) begin
        chk(rb0 == memf(a), "R4 first byte", rb0, memf(a));
        chk(rb1 == memf(a + 16'd1), "R4 second byte", rb1, memf(a + 16'd1));
      end
      if (k == 3'd2) chk(rb0 == memf(a), "R7 pointer read", rb0, memf(a));
      if (k == 3'd4) chk(rb0 == memf({p2, a[7:0]}), "R6 R7 indirect read", rb0, memf({p2, a[7:0]}));
      if (k == 3'd3 || k == 3'd5) begin
        logic [15:0] ewa;
        ewa = (k == 3'd3) ? a : {p2, a[7:0]};
        chk(wd_seen == wd, "R8 write data", wd_seen, wd);
        chk(wa == ewa, "R6 R8 write address", wa, ewa);
      end
      chk(hi_end == p2 && oe_end == 1'b0, "R9 restore", {hi_end, oe_end}, {p2, 1'b0});
    end

    // R10 request without valid is an idle cycle
    run(3'd1, 1'b0, 16'h2345, 8'h00, 8'h10, 1'b0);
    chk(n_psen == 0 && n_ale == 2, "R10 valid low ignored", {n_psen, n_ale}, 2);
    chk(hi0 == 8'h10 && oe0 == 1'b0, "R10 idle bus", {hi0, oe0}, {8'h10, 1'b0});

    // R11 reset in the middle of an external fetch
    @(negedge clk);
    while (!slot_open) @(negedge clk);
    req_valid = 1; req_kind = 3'd1; req_addr = 16'h3456; ext_acc = 0; p2_sfr = 8'h77;
    @(negedge clk); req_valid = 0; req_kind = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk(psen_n && !ale && ad_oe == 0, "R11 mid-cycle reset", {psen_n, ale, ad_oe[0]}, 3'b100);
    rst = 0;
    @(negedge clk);
    chk(ale && psen_n && a_hi == 8'h77, "R11 restart idle", {ale, psen_n, a_hi}, {2'b11, 8'h77});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule